// File: doc/BRIEF.md
# Two-stage bark/bite watchdog timer

This block is a watchdog peripheral that counts ticks of a fixed-rate timer clock. Software writes two thresholds, both in timer ticks. It then sets the enable bit and, at regular intervals, writes the restart register to pull the count back to zero. If software stops servicing the block, the count climbs in stages:

- At the bark threshold the block raises a level interrupt as an early warning.
- At the bite threshold it issues a one-cycle system reset request.

The block also keeps a sticky cause flag that software reads after the reset. This flag shows whether the watchdog caused the last reset.

The block has two reset inputs. `rst_n` is the ordinary system reset, and it is the reset that a bite leads to. It clears the enable, the thresholds and the counter. `por_n` is the power-on reset. It clears everything, and it is the only input that clears the cause flag. Register access uses a plain 32-bit write strobe. The read path decodes the address with no handshake. `LAYOUT_ALT` selects one of two address maps.

Top module: `wdog_bark_bite`

## Requirements
- R1: With `LAYOUT_ALT`=0 the restart, enable, cause, bark and bite registers are at byte offsets 0x04, 0x08, 0x0C, 0x10 and 0x14. With `LAYOUT_ALT`=1 they are at 0x38, 0x40, 0x44, 0x4C and 0x5C. Any other address reads 0 and ignores writes.
- R2: Enable register bit 0 starts and stops the counter. A read of the enable register returns the running state in bit 0, with every other bit 0.
- R3: While the counter runs it advances by one on each clock edge that follows the enable write. A disable write lets that edge count, and the counter then holds its value. While stopped, `bark_irq` and `bite_req` stay low.
- R4: A restart write with bit 0 = 1 sets the count to zero and drops `bark_irq`. A restart write with bit 0 = 0 changes nothing.
- R5: `bark_irq` rises in the cycle in which the count equals the bark threshold. It then stays high until a restart or a disable.
- R6: `bite_req` is high for exactly one cycle, in the cycle in which the count reaches a non-zero bite threshold. When the two thresholds are equal, `bark_irq` and `bite_req` rise together.
- R7: The count saturates at the bite threshold. No further bite pulse occurs and the count does not wrap before a restart.
- R8: Cause register bit 0 becomes 1 one cycle after a bite pulse. It survives `rst_n` and is cleared only by `por_n`.
- R9: The bark and bite thresholds can be written at any time. They read back as the low `CNT_W` bits of the written data, zero-extended, and reset to 0.
- R10: With a bite threshold of 0 the counter stays at zero and never bites. With a bark threshold of 0, `bark_irq` is high whenever the block is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| por_n | input | 1 | Active-low power-on reset, also clears the cause flag |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| bark_irq | output | 1 | Early-warning interrupt, level |
| bite_req | output | 1 | System reset request, one-cycle pulse |

## Verification
The main check sweeps every bark/bite pair from 0 to 10. For each pair it compares both outputs in every cycle against the count computed as min(cycles since enable, bite). This separates three cases: bark before bite, bark equal to bite (simultaneous rise), and bark past bite (never fires). The zero thresholds fall inside the same sweep. A second pattern stops the count partway through, waits, and resumes. Holding with no drift shows up as a bark that arrives exactly one tick after the resume. Restart writes with bit 0 set and with bit 0 clear separate a real reload from an ignored write. Address readbacks on an alternate-layout instance, and the two reset pulses applied one after the other, separate the two register maps and the two reset domains of the cause flag.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [2:0] {
      WR_RESTART,
      WR_ENABLE,
      WR_CAUSE,
      WR_BARK,
      WR_BITE,
      WR_NONE
   } wdog_reg_e;

   // Byte offset of each register for the two address maps.
   function automatic logic [7:0] reg_offset(input bit alt, input wdog_reg_e r);
      logic [7:0] off;
      case (r)
         WR_RESTART: off = alt ? 8'h38 : 8'h04;
         WR_ENABLE:  off = alt ? 8'h40 : 8'h08;
         WR_CAUSE:   off = alt ? 8'h44 : 8'h0C;
         WR_BARK:    off = alt ? 8'h4C : 8'h10;
         WR_BITE:    off = alt ? 8'h5C : 8'h14;
         default:    off = 8'hFF;
      endcase
      return off;
   endfunction

endpackage

// File: rtl/wdog_decode.sv
module wdog_decode #(
   parameter int ADDR_W     = 8,
   parameter bit LAYOUT_ALT = 1'b0
) (
   input  logic [ADDR_W-1:0]  addr,
   output wdog_pkg::wdog_reg_e which
);
   import wdog_pkg::*;

   localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(reg_offset(LAYOUT_ALT, WR_RESTART));
   localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(reg_offset(LAYOUT_ALT, WR_ENABLE));
   localparam logic [ADDR_W-1:0] A_CAUSE   = ADDR_W'(reg_offset(LAYOUT_ALT, WR_CAUSE));
   localparam logic [ADDR_W-1:0] A_BARK    = ADDR_W'(reg_offset(LAYOUT_ALT, WR_BARK));
   localparam logic [ADDR_W-1:0] A_BITE    = ADDR_W'(reg_offset(LAYOUT_ALT, WR_BITE));

   always_comb begin
      if      (addr == A_RESTART) which = WR_RESTART;
      else if (addr == A_ENABLE)  which = WR_ENABLE;
      else if (addr == A_CAUSE)   which = WR_CAUSE;
      else if (addr == A_BARK)    which = WR_BARK;
      else if (addr == A_BITE)    which = WR_BITE;
      else                        which = WR_NONE;
   end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
   parameter int CNT_W = 29
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  wdog_pkg::wdog_reg_e which,
   input  logic [31:0]         wdata,
   output logic                en_q,
   output logic                en_d,
   output logic                restart,
   output logic [CNT_W-1:0]    bark_q,
   output logic [CNT_W-1:0]    bite_q
);
   import wdog_pkg::*;

   // Next enable state, seen by the core in the same cycle as the write.
   assign en_d    = (wr && which == WR_ENABLE) ? wdata[0] : en_q;
   assign restart = wr && (which == WR_RESTART) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         bark_q <= '0;
         bite_q <= '0;
      end else begin
         en_q <= en_d;
         if (wr && which == WR_BARK) bark_q <= wdata[CNT_W-1:0];
         if (wr && which == WR_BITE) bite_q <= wdata[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
   parameter int CNT_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_q,
   input  logic             en_d,
   input  logic             restart,
   input  logic [CNT_W-1:0] bark,
   input  logic [CNT_W-1:0] bite,
   output logic             irq_q,
   output logic             bite_q
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             at_top, hit;

   always_comb begin
      at_top = (cnt_q >= bite);
      if (restart)             cnt_d = '0;
      else if (en_q && !at_top) cnt_d = cnt_q + CNT_W'(1);
      else                     cnt_d = cnt_q;
      hit = en_q && en_d && !restart && !at_top && (cnt_q + CNT_W'(1) == bite);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         irq_q  <= 1'b0;
         bite_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         irq_q  <= en_d && (cnt_d >= bark);
         bite_q <= hit;
      end
   end

   // R6: the reset request lasts one cycle
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bite_q |=> !bite_q);
   // R3: a stopped counter drives neither output
   a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (!irq_q && !bite_q));
   // R7: the count holds at the bite threshold
   a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !restart && cnt_q >= bite) |=> $stable(cnt_q));
   // R4: a restart reloads zero
   a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));
   // R5: the bark level holds while nothing clears it
   a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !restart && en_d && $stable(bark)) |=> irq_q);

endmodule

// File: rtl/wdog_cause.sv
module wdog_cause (
   input  logic clk,
   input  logic por_n,
   input  logic bite,
   output logic cause_q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)    cause_q <= 1'b0;
      else if (bite) cause_q <= 1'b1;
   end

   // R8: set by a bite, kept until power-on reset
   a_r8_set_on_bite: assert property (@(posedge clk) disable iff (!por_n)
      bite |=> cause_q);
   a_r8_sticky: assert property (@(posedge clk) disable iff (!por_n)
      cause_q |=> cause_q);

endmodule

// File: rtl/wdog_bark_bite.sv
module wdog_bark_bite #(
   parameter int CNT_W      = 29,
   parameter int ADDR_W     = 8,
   parameter bit LAYOUT_ALT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bark_irq,
   output logic              bite_req
);
   import wdog_pkg::*;

   localparam int PAD_W = 32 - CNT_W;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("wdog_bark_bite: CNT_W must lie in 2..32");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("wdog_bark_bite: ADDR_W must be at least 7");
      end
   endgenerate

   logic             sys_rst_n;
   wdog_reg_e        which;
   logic             en_q, en_d, restart, cause_q;
   logic [CNT_W-1:0] bark_q, bite_q;
   logic [31:0]      bark32, bite32;

   assign sys_rst_n = rst_n & por_n;

   wdog_decode #(.ADDR_W(ADDR_W), .LAYOUT_ALT(LAYOUT_ALT)) u_dec (
      .addr (bus_addr),
      .which(which)
   );

   wdog_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (sys_rst_n),
      .wr     (bus_wr),
      .which  (which),
      .wdata  (bus_wdata),
      .en_q   (en_q),
      .en_d   (en_d),
      .restart(restart),
      .bark_q (bark_q),
      .bite_q (bite_q)
   );

   wdog_core #(.CNT_W(CNT_W)) u_core (
      .clk    (clk),
      .rst_n  (sys_rst_n),
      .en_q   (en_q),
      .en_d   (en_d),
      .restart(restart),
      .bark   (bark_q),
      .bite   (bite_q),
      .irq_q  (bark_irq),
      .bite_q (bite_req)
   );

   wdog_cause u_cause (
      .clk    (clk),
      .por_n  (por_n),
      .bite   (bite_req),
      .cause_q(cause_q)
   );

   generate
      if (PAD_W == 0) begin : g_full
         assign bark32 = bark_q;
         assign bite32 = bite_q;
      end else begin : g_pad
         assign bark32 = {{PAD_W{1'b0}}, bark_q};
         assign bite32 = {{PAD_W{1'b0}}, bite_q};
      end
   endgenerate

   always_comb begin
      case (which)
         WR_ENABLE: bus_rdata = {31'b0, en_q};
         WR_CAUSE:  bus_rdata = {31'b0, cause_q};
         WR_BARK:   bus_rdata = bark32;
         WR_BITE:   bus_rdata = bite32;
         default:   bus_rdata = 32'b0;
      endcase
   end

endmodule

// File: tb/sim_wdog_bark_bite.sv
module sim_wdog_bark_bite;
   localparam logic [7:0] A_RST = 8'h04, A_EN = 8'h08, A_CAUSE = 8'h0C,
                          A_BARK = 8'h10, A_BITE = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0, por_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] rdata0, rdata1;
   logic        irq0, bite0, irq1, bite1;
   int          n_chk = 0, n_bad = 0;
   logic [31:0] v;

   always #4 clk = ~clk;

   wdog_bark_bite #(.CNT_W(8), .ADDR_W(8), .LAYOUT_ALT(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
      .bark_irq(irq0), .bite_req(bite0));

   wdog_bark_bite #(.CNT_W(8), .ADDR_W(8), .LAYOUT_ALT(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
      .bark_irq(irq1), .bite_req(bite1));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Called at a falling edge; the write lands on the next rising edge.
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 8'h00;
   endtask

   task automatic rd(input logic [7:0] a, input bit alt, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = alt ? rdata1 : rdata0;
      bus_addr = 8'h00;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; por_n = 1'b1;
      @(negedge clk);

      // Reset state
      chk(irq0 == 0 && bite0 == 0, "R3 reset outputs", {irq0, bite0}, 0);
      rd(A_EN, 0, v);    chk(v == 0, "R2 reset enable", v, 0);
      rd(A_CAUSE, 0, v); chk(v == 0, "R8 reset cause", v, 0);
      rd(A_BARK, 0, v);  chk(v == 0, "R9 reset bark", v, 0);

      // R9 readback width, R2 enable readback
      wr(A_BARK, 32'hFFFF_FF5A); rd(A_BARK, 0, v); chk(v == 32'h5A, "R9 bark readback", v, 32'h5A);
      wr(A_BITE, 32'h1234_56C3); rd(A_BITE, 0, v); chk(v == 32'hC3, "R9 bite readback", v, 32'hC3);
      wr(A_EN, 32'hFFFF_FFFF);   rd(A_EN, 0, v);   chk(v == 1, "R2 enable readback", v, 1);
      wr(A_EN, 32'hFFFF_FFFE);   rd(A_EN, 0, v);   chk(v == 0, "R2 disable readback", v, 0);

      // R1 alternate layout on u1, default map on u0
      wr(8'h4C, 32'h33);
      rd(8'h4C, 1, v); chk(v == 32'h33, "R1 alt bark offset", v, 32'h33);
      rd(8'h10, 1, v); chk(v == 0, "R1 alt unmapped", v, 0);
      rd(8'h10, 0, v); chk(v == 32'h5A, "R1 default bark untouched", v, 32'h5A);
      wr(8'h5C, 32'h44); rd(8'h5C, 1, v); chk(v == 32'h44, "R1 alt bite offset", v, 32'h44);
      wr(8'h40, 32'h1);  rd(8'h40, 1, v); chk(v == 1, "R1 alt enable offset", v, 1);
      wr(8'h40, 32'h0);

      // Sweep bark/bite pairs: count = min(k, bite)
      for (int b = 0; b <= 10; b++) begin
         for (int t = 0; t <= 10; t++) begin
            wr(A_EN, 0); wr(A_RST, 1); wr(A_BARK, b); wr(A_BITE, t); wr(A_EN, 1);
            for (int k = 0; k <= t + 3; k++) begin
               chk(irq0 == (((k < t) ? k : t) >= b),
                   (t == 0) ? "R10 bark zero-bite" : "R5 bark timing",
                   irq0, (((k < t) ? k : t) >= b));
               chk(bite0 == (t != 0 && k == t),
                   (t == 0) ? "R10 no bite" : ((k > t) ? "R7 no repeat" : "R6 bite timing"),
                   bite0, (t != 0 && k == t));
               @(negedge clk);
            end
         end
      end
      rd(A_CAUSE, 0, v); chk(v == 1, "R8 cause after bite", v, 1);

      // R3 hold while disabled, R4 restart, R5 level, R7 saturation
      wr(A_EN, 0); wr(A_RST, 1); wr(A_BARK, 5); wr(A_BITE, 20); wr(A_EN, 1);
      repeat (3) @(negedge clk);           // count 3
      wr(A_EN, 0);                         // count 4 then held
      for (int i = 0; i < 10; i++) begin
         chk(irq0 == 0 && bite0 == 0, "R3 quiet while off", {irq0, bite0}, 0);
         @(negedge clk);
      end
      wr(A_EN, 1);                         // still 4
      chk(irq0 == 0, "R3 held count", irq0, 0);
      @(negedge clk);                      // 5
      chk(irq0 == 1, "R3 resume one tick to bark", irq0, 1);
      repeat (3) @(negedge clk);
      chk(irq0 == 1, "R5 level stays", irq0, 1);
      wr(A_RST, 1);                        // 0
      chk(irq0 == 0, "R4 restart clears bark", irq0, 0);
      repeat (2) @(negedge clk);           // 2
      wr(A_RST, 0);                        // 3, ignored
      @(negedge clk);                      // 4
      chk(irq0 == 0, "R4 ignored restart", irq0, 0);
      @(negedge clk);                      // 5
      chk(irq0 == 1, "R4 count not reloaded", irq0, 1);
      repeat (14) @(negedge clk);          // 19
      chk(bite0 == 0, "R6 before bite", bite0, 0);
      @(negedge clk);                      // 20
      chk(bite0 == 1, "R6 bite at threshold", bite0, 1);
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         chk(bite0 == 0 && irq0 == 1, "R7 saturated no wrap", {irq0, bite0}, 2'b10);
      end
      wr(A_EN, 0);
      chk(irq0 == 0, "R5 disable clears bark", irq0, 0);

      // R8 survives system reset, cleared by power-on reset
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
      rd(A_CAUSE, 0, v); chk(v == 1, "R8 kept over rst_n", v, 1);
      rd(A_BITE, 0, v);  chk(v == 0, "R9 rst_n clears bite", v, 0);
      por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
      rd(A_CAUSE, 0, v); chk(v == 0, "R8 cleared by por_n", v, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule